// File: doc/BRIEF.md
# Periodic Overlapped-Readout Converter Capture Engine

This block runs a successive-approximation converter whose chip-select line also starts each conversion. While enabled it repeats a frame at a programmable interval measured in clock cycles. Each frame begins with a quiet interval with the select line low. A short high pulse on the select line then starts a conversion. The select line drops again, and while that conversion runs the engine clocks out the result of the *previous* conversion on the serial data line. Overlapping the readout with the conversion lets the converter run at its full rate. The cost is that the first word after the engine starts from idle holds a stale value.

Each result is packed into a 32-bit word and offered on a valid/ready stream. A static mode input selects between unsigned results, which are zero-extended, and two's-complement results, which are sign-extended. The stream does not buffer. A word stays on the output, unchanged, until the consumer takes it. If a new word arrives while the old one is still waiting, the new word is lost and a sticky overflow flag is set. A consumer that keeps ready high always receives every word. When the enable input falls, the frame in progress runs to the end of its readout and delivers its word. The engine then idles with the select line and the serial clock both low.

Top module: `conv_stream_capture`

## Requirements
- R1: After reset, cnv_cs, sclk, m_tvalid and overflow are all 0.
- R2: The first frame starts on the clock edge that samples enable high while the engine is idle. Every frame holds cnv_cs low for QUIET_CYC cycles from its start and then high for exactly CNVH_CYC cycles. With the defaults, cnv_cs is first seen high QUIET_CYC+1 cycles after enable is set.
- R3: Right after the select pulse, sclk gives exactly DATA_BITS pulses, each one cycle high followed by one cycle low, with cnv_cs low. sdi is sampled at the clock edge that ends each high cycle, most significant bit first.
- R4: The word delivered in frame k is the result the converter held when frame k's select pulse rose, which is the result of conversion k-1. m_tuser is 1 on the first word after a start from idle and 0 on every later word.
- R5: When sign_mode is 0 the DATA_BITS-wide result is zero-extended to 32 bits. When sign_mode is 1 bit DATA_BITS-1 is copied into all upper bits.
- R6: Select pulses repeat every E cycles. E is the period input, latched at each frame start, with two substitutions: a period of 0 selects DEFAULT_PERIOD, and any value below QUIET_CYC+CNVH_CYC+2*DATA_BITS is raised to that minimum.
- R7: m_tvalid rises two cycles after the cycle that holds the last sclk high. While m_tvalid is 1 and m_tready is 0, m_tdata and m_tuser hold steady. m_tvalid falls after a transfer unless a new word is loaded in the same cycle.
- R8: If a new word is ready while m_tvalid is 1 and m_tready is 0, the new word is discarded, the held word is kept, and overflow goes to 1 and stays there until reset.
- R9: When enable falls, the frame in progress finishes its readout and delivers its word. No further select pulse occurs, and cnv_cs and sclk stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| enable | input | 1 | Run frames while high |
| period | input | PERIOD_W | Frame interval in clock cycles (0 = default) |
| sign_mode | input | 1 | 1 = two's-complement results, 0 = unsigned |
| sdi | input | 1 | Serial result data from the converter |
| cnv_cs | output | 1 | Combined chip select / conversion start |
| sclk | output | 1 | Serial clock to the converter |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream consumer ready |
| m_tdata | output | 32 | Packed result word |
| m_tuser | output | 1 | Discard flag: first word after a start from idle |
| overflow | output | 1 | Sticky lost-word flag |

## Verification
The capture path is driven by a behavioural converter model. Each select pulse latches a fresh random conversion value, and the model shifts out the previous value on falling sclk edges. A wrong bit order, an off-by-one sample point, or a missing one-frame delay each produces a data mismatch.

Directed runs use a zero period, a period below the minimum, a period exactly at the minimum, and a long period, so that default selection, clamping and normal latching each show up in the measured pulse spacing. Random runs combine periods, sign modes and random ready patterns, which separates zero-extension from sign-extension and exercises holding a word under back-pressure. A final run holds ready low across several frames, which checks that the held word stays frozen, that the dropped words never appear, and that the overflow flag stays set.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_QUIET = 3'd1,
    PH_PULSE = 3'd2,
    PH_READ  = 3'd3,
    PH_WAIT  = 3'd4
  } phase_e;

  localparam int STREAM_W = 32;

endpackage

// File: rtl/cap_frame_timer.sv
module cap_frame_timer #(
  parameter int QUIET_CYC      = 3,
  parameter int CNVH_CYC       = 2,
  parameter int DATA_BITS      = 18,
  parameter int PERIOD_W       = 16,
  parameter int DEFAULT_PERIOD = 63
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  output logic                cs_o,
  output logic                sclk_o,
  output logic                cap_o,
  output logic                last_o,
  output logic                start_idle_o
);
  import cap_pkg::*;

  localparam int READ_START = QUIET_CYC + CNVH_CYC;
  localparam int READ_END   = READ_START + 2 * DATA_BITS;
  localparam int MIN_PERIOD = READ_END;

  logic                active_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] eff_q;
  logic [PERIOD_W-1:0] req;
  logic [PERIOD_W-1:0] eff_d;
  logic [PERIOD_W-1:0] offs;
  phase_e              phase;

  // Effective interval: zero picks the default, short values are raised.
  always_comb begin
    req   = (period == '0) ? PERIOD_W'(DEFAULT_PERIOD) : period;
    eff_d = (req < PERIOD_W'(MIN_PERIOD)) ? PERIOD_W'(MIN_PERIOD) : req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      eff_q    <= PERIOD_W'(MIN_PERIOD);
    end else if (!active_q) begin
      if (enable) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        eff_q    <= eff_d;
      end
    end else if (cnt_q == eff_q - 1'b1) begin
      if (enable) begin
        cnt_q <= '0;
        eff_q <= eff_d;
      end else begin
        active_q <= 1'b0;
      end
    end else if (!enable && cnt_q >= PERIOD_W'(READ_END)) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    offs = cnt_q - PERIOD_W'(READ_START);
    if (!active_q)                             phase = PH_IDLE;
    else if (cnt_q < PERIOD_W'(QUIET_CYC))     phase = PH_QUIET;
    else if (cnt_q < PERIOD_W'(READ_START))    phase = PH_PULSE;
    else if (cnt_q < PERIOD_W'(READ_END))      phase = PH_READ;
    else                                       phase = PH_WAIT;
  end

  assign cs_o         = (phase == PH_PULSE);
  assign sclk_o       = (phase == PH_READ) && offs[0];
  assign cap_o        = sclk_o;
  assign last_o       = sclk_o && (offs == PERIOD_W'(2 * DATA_BITS - 1));
  assign start_idle_o = !active_q && enable;

  assert_period_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (eff_q >= PERIOD_W'(MIN_PERIOD)) && (cnt_q < eff_q));

  assert_cs_sclk_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_o |-> !sclk_o);

  assert_quiet_before_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |-> $past(!sclk_o));

endmodule

// File: rtl/cap_serial_shifter.sv
module cap_serial_shifter #(
  parameter int DATA_BITS = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap,
  input  logic                 last,
  input  logic                 sdi,
  output logic [DATA_BITS-1:0] raw_o,
  output logic                 done_o
);
  logic [DATA_BITS-1:0] sh_q;
  logic                 done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (cap) sh_q <= {sh_q[DATA_BITS-2:0], sdi};
      done_q <= cap && last;
    end
  end

  assign raw_o  = sh_q;
  assign done_o = done_q;

  assert_done_after_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(cap));

endmodule

// File: rtl/cap_word_packer.sv
module cap_word_packer #(
  parameter int DATA_BITS = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] raw,
  input  logic                 sign_mode,
  input  logic                 start_idle,
  input  logic                 tready,
  output logic                 tvalid_o,
  output logic [31:0]          tdata_o,
  output logic                 tuser_o,
  output logic                 ovf_o
);
  logic [31:0] packed_w;
  logic        tvalid_q;
  logic [31:0] tdata_q;
  logic        tuser_q;
  logic        first_q;
  logic        ovf_q;

  generate
    if (DATA_BITS >= 32) begin : g_full
      assign packed_w = raw[31:0];
    end else begin : g_ext
      assign packed_w = {{(32 - DATA_BITS){sign_mode & raw[DATA_BITS-1]}}, raw};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tvalid_q <= 1'b0;
      tdata_q  <= '0;
      tuser_q  <= 1'b0;
      first_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (start_idle)  first_q <= 1'b1;
      else if (done)   first_q <= 1'b0;

      if (done) begin
        if (tvalid_q && !tready) begin
          ovf_q <= 1'b1;
        end else begin
          tvalid_q <= 1'b1;
          tdata_q  <= packed_w;
          tuser_q  <= first_q;
        end
      end else if (tvalid_q && tready) begin
        tvalid_q <= 1'b0;
      end
    end
  end

  assign tvalid_o = tvalid_q;
  assign tdata_o  = tdata_q;
  assign tuser_o  = tuser_q;
  assign ovf_o    = ovf_q;

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid_o && !tready) |=> (tvalid_o && $stable(tdata_o) && $stable(tuser_o)));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(done && tvalid_o && !tready));

  generate
    if (DATA_BITS < 32) begin : g_chk
      assert_upper_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tvalid_o |-> ($countones(tdata_o[31:DATA_BITS]) == 0 ||
                      $countones(tdata_o[31:DATA_BITS]) == 32 - DATA_BITS));
    end
  endgenerate

endmodule

// File: rtl/conv_stream_capture.sv
module conv_stream_capture #(
  parameter int QUIET_CYC      = 3,
  parameter int CNVH_CYC       = 2,
  parameter int DATA_BITS      = 18,
  parameter int PERIOD_W       = 16,
  parameter int DEFAULT_PERIOD = 63
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  input  logic                sign_mode,
  input  logic                sdi,
  output logic                cnv_cs,
  output logic                sclk,
  output logic                m_tvalid,
  input  logic                m_tready,
  output logic [31:0]         m_tdata,
  output logic                m_tuser,
  output logic                overflow
);
  logic                 cap;
  logic                 last;
  logic                 start_idle;
  logic [DATA_BITS-1:0] raw;
  logic                 done;

  cap_frame_timer #(
    .QUIET_CYC(QUIET_CYC), .CNVH_CYC(CNVH_CYC), .DATA_BITS(DATA_BITS),
    .PERIOD_W(PERIOD_W), .DEFAULT_PERIOD(DEFAULT_PERIOD)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
    .cs_o(cnv_cs), .sclk_o(sclk), .cap_o(cap), .last_o(last),
    .start_idle_o(start_idle)
  );

  cap_serial_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .cap(cap), .last(last), .sdi(sdi),
    .raw_o(raw), .done_o(done)
  );

  cap_word_packer #(.DATA_BITS(DATA_BITS)) u_pack (
    .clk(clk), .rst_n(rst_n), .done(done), .raw(raw), .sign_mode(sign_mode),
    .start_idle(start_idle), .tready(m_tready), .tvalid_o(m_tvalid),
    .tdata_o(m_tdata), .tuser_o(m_tuser), .ovf_o(overflow)
  );

endmodule

// File: tb/conv_stream_capture_tb_top.sv
module conv_stream_capture_tb_top;
  localparam int Q   = 3;
  localparam int H   = 2;
  localparam int B   = 18;
  localparam int PW  = 16;
  localparam int DEF = 63;
  localparam int MINP = Q + H + 2 * B;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, sign_mode = 1'b0, sdi = 1'b0;
  logic [PW-1:0] period = '0;
  logic m_tready = 1'b0;
  logic cnv_cs, sclk, m_tvalid, m_tuser, overflow;
  logic [31:0] m_tdata;

  conv_stream_capture #(.QUIET_CYC(Q), .CNVH_CYC(H), .DATA_BITS(B),
    .PERIOD_W(PW), .DEFAULT_PERIOD(DEFAULT_PERIOD_C)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
    .sign_mode(sign_mode), .sdi(sdi), .cnv_cs(cnv_cs), .sclk(sclk),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tuser(m_tuser), .overflow(overflow));
  localparam int DEFAULT_PERIOD_C = DEF;

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [B-1:0] r, input logic sm);
    logic [31:0] w = 32'(r);
    if (sm && r[B-1]) w = w | ~((32'd1 << B) - 1);
    return w;
  endfunction

  function automatic int eff_of(input int p);
    int e = (p == 0) ? DEF : p;
    return (e < MINP) ? MINP : e;
  endfunction

  // converter model and monitor state
  logic [B-1:0] adc_conv = 18'h2a5c3, out_word = '0;
  int  bitp = 0;
  bit  p_cs = 0, p_sclk = 0;
  int  last_rise = -1, rise_total = 0, sclk_cnt = 0, hi_len = 0;
  int  exp_eff = MINP;
  bit  first_exp = 0, cmp_en = 1;
  int  ready_mode = 0;
  logic [31:0] exp_d [0:1023];
  bit          exp_u [0:1023];
  int  wr = 0, rd = 0, xfers = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cnv_cs && !p_cs) begin
        if (last_rise >= 0) begin
          check(cyc - last_rise == exp_eff, "R6 pulse spacing", cyc - last_rise, exp_eff);
          check(sclk_cnt == B, "R3 sclk pulse count", sclk_cnt, B);
        end
        last_rise = cyc;
        rise_total++;
        sclk_cnt = 0;
        out_word = adc_conv;
        adc_conv = B'($urandom);
        bitp = B - 1;
        sdi = out_word[B-1];
        exp_d[wr % 1024] = pack(out_word, sign_mode);
        exp_u[wr % 1024] = first_exp;
        first_exp = 0;
        wr++;
      end
      if (cnv_cs) hi_len++;
      if (!cnv_cs && p_cs) begin
        check(hi_len == H, "R2 pulse width", hi_len, H);
        hi_len = 0;
      end
      if (sclk && !p_sclk) sclk_cnt++;
      if (!sclk && p_sclk && bitp > 0) begin
        bitp--;
        sdi = out_word[bitp];
      end
      p_cs = cnv_cs;
      p_sclk = sclk;
      case (ready_mode)
        0: m_tready = 1'b0;
        1: m_tready = 1'b1;
        default: m_tready = 1'($urandom);
      endcase
      if (m_tvalid && m_tready) begin
        xfers++;
        if (cmp_en) begin
          if (rd == wr) check(0, "R4 unexpected word", m_tdata, 0);
          else begin
            check(m_tdata == exp_d[rd % 1024], "R4/R5 word value", m_tdata, exp_d[rd % 1024]);
            check(m_tuser == exp_u[rd % 1024], "R4 discard flag", m_tuser, exp_u[rd % 1024]);
            rd++;
          end
        end
      end
    end
  end

  task automatic run(input int p, input bit sm, input int nfr, input bit chk_first);
    int target;
    int k;
    period = PW'(p);
    sign_mode = sm;
    exp_eff = eff_of(p);
    last_rise = -1;
    first_exp = 1;
    ready_mode = 2;
    target = rise_total + nfr;
    @(negedge clk);
    enable = 1'b1;
    if (chk_first) begin
      k = 0;
      do begin @(negedge clk); k++; end while (!cnv_cs && k < 50);
      check(k == Q + 1, "R2 first pulse delay", k, Q + 1);
    end
    while (rise_total < target) @(negedge clk);
    enable = 1'b0;
    repeat (3 * exp_eff) @(negedge clk);
    check(rise_total == target, "R9 no pulse after disable", rise_total, target);
    check(!cnv_cs && !sclk, "R9 idle lines low", {cnv_cs, sclk}, 0);
    check(sclk_cnt == B, "R3 last frame readout", sclk_cnt, B);
    check(rd == wr, "R9 last word delivered", rd, wr);
  endtask

  logic [31:0] held;
  int hold_rd;
  bit done_flag = 0;

  initial begin
    repeat (3) @(negedge clk);
    check(!cnv_cs && !sclk, "R1 reset lines", {cnv_cs, sclk}, 0);
    check(!m_tvalid, "R1 reset valid", m_tvalid, 0);
    check(!overflow, "R1 reset overflow", overflow, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!cnv_cs && !m_tvalid, "R1 idle after reset", {cnv_cs, m_tvalid}, 0);

    void'($urandom(32'd1234));
    run(0,   1'b0, 4, 1'b1);   // R6 default
    run(20,  1'b1, 4, 1'b1);   // R6 clamp
    run(MINP,1'b1, 5, 1'b0);   // R6 exact minimum
    run(100, 1'b0, 3, 1'b1);
    for (int i = 0; i < 8; i++)
      run(MINP + int'($urandom_range(0, 150)), 1'($urandom), 3 + int'($urandom_range(0, 3)), 1'b0);

    // R8 overflow under held ready
    cmp_en = 0;
    hold_rd = wr;
    period = PW'(MINP);
    sign_mode = 1'b1;
    exp_eff = MINP;
    last_rise = -1;
    first_exp = 1;
    ready_mode = 0;
    @(negedge clk);
    enable = 1'b1;
    while (!m_tvalid) @(negedge clk);
    held = m_tdata;
    check(m_tuser == 1'b1, "R4 first word flagged", m_tuser, 1);
    check(held == exp_d[hold_rd % 1024], "R4 stale first word", held, exp_d[hold_rd % 1024]);
    check(!overflow, "R8 no overflow yet", overflow, 0);
    repeat (3 * MINP) @(negedge clk);
    check(m_tdata == held && m_tvalid, "R8 held word kept", m_tdata, held);
    check(overflow, "R8 overflow set", overflow, 1);
    enable = 1'b0;
    repeat (2 * MINP) @(negedge clk);
    xfers = 0;
    ready_mode = 1;
    repeat (20) @(negedge clk);
    check(xfers == 1, "R8 only held word left", xfers, 1);
    check(!m_tvalid, "R7 valid falls after transfer", m_tvalid, 0);
    check(overflow, "R8 overflow sticky", overflow, 1);
    rd = wr;
    cmp_en = 1;
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done_flag) begin
      check(0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule